// File: doc/BRIEF.md
# Serial Port with Register Interface and Masked Interrupts

This block is a byte-wide asynchronous serial port: one start bit, eight data bits sent least significant bit first, one stop bit, no parity. A host reaches it through a small word-addressed register port. It writes bytes to send, reads received bytes, reads a status word and sets a control word. Each status cause has a matching interrupt-enable bit in the control word, and the single interrupt line is the OR of the enabled causes.

The divisor register sets the bit period. Each serial bit lasts divisor+1 clock cycles, in both directions. The transmitter has no holding register. A byte written while it is busy is dropped and flagged. Internally the transmitter takes bytes over a valid/ready pair, with ready high only while the line is idle. The receiver has no such back-pressure, because the serial line cannot be stalled. A completed byte is offered once. It is taken only if the receive slot is empty, or is being read in that same cycle. Otherwise it is lost and flagged. Reads have side effects: a status read clears the sticky error and change flags, and a receive-data read empties the receive slot.

Top module: `ser_uart`

## Requirements
- R1: After reset the status word reads 0x0060, which is bit 5 (transmitter empty) and bit 6 (transmit ready). Control reads 0, the divisor reads its reset parameter, txd is high and irq is low.
- R2: The registers sit at word offsets 0 receive data, 1 transmit data, 2 status, 3 control, 4 divisor and 5 end-of-packet. Control keeps 13 bits, the divisor keeps DIV_W bits, end-of-packet keeps 16 bits and transmit data keeps 8 bits. Offsets 6 and 7 read as 0. Read data appears on reg_rdata in the cycle after reg_rd and holds until the next read.
- R3: Writes to offset 0 and offset 2 change nothing.
- R4: A write to offset 1 while the transmitter is idle drives the start bit on txd from the next cycle. Then come the 8 data bits LSB first and a high stop bit, each lasting divisor+1 cycles. txd is high when the transmitter is idle.
- R5: Status bits 5 and 6 are low from the accepting write until the stop bit has finished, and high otherwise.
- R6: A write to offset 1 while the transmitter is busy leaves the frame in progress unchanged and sets status bit 4 (transmit overrun).
- R7: A byte received on rxd with a high stop bit appears at offset 0 and sets status bit 7 (receive ready).
- R8: Reading offset 0 clears status bit 7.
- R9: A byte that completes while status bit 7 is set is dropped, offset 0 keeps the older byte, and status bit 3 (receive overrun) is set.
- R10: A frame whose stop bit is low sets status bit 1 (framing error). If its data bits are also all zero, it sets status bit 2 (break) as well.
- R11: Status bit 8 is the OR of bits 0 to 4. A status read returns the value held before the read and then clears bits 0 to 4, 8 and 10. A flag that sets in the same cycle survives the read.
- R12: irq is high exactly when some status bit among 0 to 8 and 10 is set together with the control bit at the same position. Control bits 9, 11 and 12 never raise irq.
- R13: rts_out follows control bit 11. Status bit 11 shows cts_in after a two-flop synchronizer, and status bit 10 sets whenever that synchronized value changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_addr | input | 3 | Register word offset |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_wdata | input | 16 | Write data |
| reg_rd | input | 1 | Read strobe for one cycle; may trigger read side effects |
| reg_rdata | output | 16 | Read data, registered |
| rxd | input | 1 | Serial receive line, idles high |
| txd | output | 1 | Serial transmit line, idles high |
| cts_in | input | 1 | Clear-to-send input, asynchronous |
| rts_out | output | 1 | Request-to-send output |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the port with DIV_W=8 and a reset divisor of 5. A whole frame then takes tens of cycles rather than thousands, so many frames fit in one short run, including runs at divisor 0 (one cycle per bit) and divisor 2. The 8-bit divisor width also makes truncation on write visible: writing 0x1234 reads back as 0x0034. Together these reach every receive ordering in the test plan: overrun on a full slot, framing error and break, and the interrupt raised by each enabled cause.

// File: rtl/ser_uart_pkg.sv
package ser_uart_pkg;

  localparam int REG_W  = 16;
  localparam int STAT_W = 13;

  typedef enum logic [2:0] {
    OFF_RX   = 3'd0,
    OFF_TX   = 3'd1,
    OFF_STAT = 3'd2,
    OFF_CTRL = 3'd3,
    OFF_DIV  = 3'd4,
    OFF_EOP  = 3'd5
  } reg_off_e;

  // status bit positions; control bit k enables status bit k
  localparam int ST_PE   = 0;
  localparam int ST_FE   = 1;
  localparam int ST_BRK  = 2;
  localparam int ST_ROE  = 3;
  localparam int ST_TOE  = 4;
  localparam int ST_TMT  = 5;
  localparam int ST_TRDY = 6;
  localparam int ST_RRDY = 7;
  localparam int ST_ERR  = 8;
  localparam int ST_CHG  = 10;
  localparam int ST_CTS  = 11;
  localparam int ST_EOP  = 12;

  localparam int CT_RTS  = 11;

  // causes that may raise the interrupt line
  localparam logic [STAT_W-1:0] IRQ_MASK = 13'h05FF;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP,
    RX_HOLD
  } rx_state_e;

endpackage

// File: rtl/ser_sync.sv
module ser_sync #(
  parameter int           W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q, out_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= RST_VAL[i];
        out_q  <= RST_VAL[i];
      end else begin
        meta_q <= d[i];
        out_q  <= meta_q;
      end
    end
    assign q[i] = out_q;
  end

endmodule

// File: rtl/ser_tx.sv
module ser_tx #(
  parameter int DATA_BITS = 8,
  parameter int DIV_W     = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DIV_W-1:0]     div,
  input  logic                 in_valid,
  input  logic [DATA_BITS-1:0] in_data,
  output logic                 in_ready,
  output logic                 txd
);

  localparam int FRAME = DATA_BITS + 2;
  localparam int BIT_W = $clog2(FRAME);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME - 1);

  logic             busy_q;
  logic [DIV_W-1:0] cnt_q;
  logic [BIT_W-1:0] bit_q;
  logic [FRAME-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '1;
    end else if (in_valid && !busy_q) begin
      busy_q <= 1'b1;
      sh_q   <= {1'b1, in_data, 1'b0};
      cnt_q  <= div;
      bit_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end else if (bit_q == LAST_BIT) begin
        busy_q <= 1'b0;
      end else begin
        bit_q <= bit_q + 1'b1;
        sh_q  <= {1'b1, sh_q[FRAME-1:1]};
        cnt_q <= div;
      end
    end
  end

  assign in_ready = !busy_q;
  assign txd      = busy_q ? sh_q[0] : 1'b1;

endmodule

// File: rtl/ser_rx.sv
module ser_rx
  import ser_uart_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int DIV_W     = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DIV_W-1:0]     div,
  input  logic                 rx_in,
  output logic                 out_valid,
  output logic [DATA_BITS-1:0] out_data,
  output logic                 out_stop_bad
);

  localparam int IDX_W = $clog2(DATA_BITS + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_BITS - 1);

  rx_state_e            st_q;
  logic [DIV_W-1:0]     cnt_q;
  logic [IDX_W-1:0]     idx_q;
  logic [DATA_BITS-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q         <= RX_IDLE;
      cnt_q        <= '0;
      idx_q        <= '0;
      sh_q         <= '0;
      out_valid    <= 1'b0;
      out_data     <= '0;
      out_stop_bad <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      unique case (st_q)
        RX_IDLE: begin
          if (!rx_in) begin
            st_q  <= RX_START;
            cnt_q <= div >> 1;
          end
        end
        RX_START: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
          end else if (!rx_in) begin
            st_q  <= RX_DATA;
            cnt_q <= div;
            idx_q <= '0;
          end else begin
            st_q <= RX_IDLE;
          end
        end
        RX_DATA: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
          end else begin
            sh_q  <= {rx_in, sh_q[DATA_BITS-1:1]};
            cnt_q <= div;
            if (idx_q == LAST_IDX) st_q <= RX_STOP;
            else idx_q <= idx_q + 1'b1;
          end
        end
        RX_STOP: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
          end else begin
            out_valid    <= 1'b1;
            out_data     <= sh_q;
            out_stop_bad <= !rx_in;
            st_q         <= rx_in ? RX_IDLE : RX_HOLD;
          end
        end
        RX_HOLD: begin
          if (rx_in) st_q <= RX_IDLE;
        end
        default: st_q <= RX_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ser_uart.sv
module ser_uart
  import ser_uart_pkg::*;
#(
  parameter int DIV_W     = 16,
  parameter int DIV_INIT  = 433,
  parameter int DATA_BITS = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  reg_addr,
  input  logic        reg_wr,
  input  logic [15:0] reg_wdata,
  input  logic        reg_rd,
  output logic [15:0] reg_rdata,
  input  logic        rxd,
  output logic        txd,
  input  logic        cts_in,
  output logic        rts_out,
  output logic        irq
);

  logic [1:0] sync_q;
  logic       rx_s, cts_s;

  ser_sync #(.W(2), .RST_VAL(2'b01)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({cts_in, rxd}),
    .q     (sync_q)
  );
  assign rx_s  = sync_q[0];
  assign cts_s = sync_q[1];

  // register state
  logic [DATA_BITS-1:0] rxd_q, txd_q;
  logic [STAT_W-1:0]    ctrl_q;
  logic [DIV_W-1:0]     div_q;
  logic [REG_W-1:0]     eop_q;
  logic fe_q, brk_q, roe_q, toe_q, rrdy_q, chg_q, cts_d;

  // access decode
  logic wr_tx, wr_ctrl, wr_div, wr_eop, rd_st, rd_rx;
  always_comb begin
    wr_tx   = reg_wr && (reg_addr == OFF_TX);
    wr_ctrl = reg_wr && (reg_addr == OFF_CTRL);
    wr_div  = reg_wr && (reg_addr == OFF_DIV);
    wr_eop  = reg_wr && (reg_addr == OFF_EOP);
    rd_st   = reg_rd && (reg_addr == OFF_STAT);
    rd_rx   = reg_rd && (reg_addr == OFF_RX);
  end

  // transmit path: valid/ready, ready only when the line is idle
  logic tx_rdy;
  ser_tx #(.DATA_BITS(DATA_BITS), .DIV_W(DIV_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .div      (div_q),
    .in_valid (wr_tx),
    .in_data  (reg_wdata[DATA_BITS-1:0]),
    .in_ready (tx_rdy),
    .txd      (txd)
  );

  // receive path: one-shot offer, no back-pressure
  logic                 rx_vld, rx_bad;
  logic [DATA_BITS-1:0] rx_byte;
  ser_rx #(.DATA_BITS(DATA_BITS), .DIV_W(DIV_W)) u_rx (
    .clk          (clk),
    .rst_n        (rst_n),
    .div          (div_q),
    .rx_in        (rx_s),
    .out_valid    (rx_vld),
    .out_data     (rx_byte),
    .out_stop_bad (rx_bad)
  );

  logic rx_take;
  assign rx_take = rx_vld && (!rrdy_q || rd_rx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxd_q  <= '0;
      txd_q  <= '0;
      ctrl_q <= '0;
      div_q  <= DIV_W'(DIV_INIT);
      eop_q  <= '0;
      fe_q   <= 1'b0;
      brk_q  <= 1'b0;
      roe_q  <= 1'b0;
      toe_q  <= 1'b0;
      rrdy_q <= 1'b0;
      chg_q  <= 1'b0;
      cts_d  <= 1'b0;
    end else begin
      if (wr_tx)   txd_q  <= reg_wdata[DATA_BITS-1:0];
      if (wr_ctrl) ctrl_q <= reg_wdata[STAT_W-1:0];
      if (wr_div)  div_q  <= reg_wdata[DIV_W-1:0];
      if (wr_eop)  eop_q  <= reg_wdata;
      if (rx_take) rxd_q  <= rx_byte;
      rrdy_q <= rx_take | (rrdy_q & ~rd_rx);
      // sticky flags: clear on status read, a new event wins
      fe_q   <= (fe_q  & ~rd_st) | (rx_vld & rx_bad);
      brk_q  <= (brk_q & ~rd_st) | (rx_vld & rx_bad & (rx_byte == '0));
      roe_q  <= (roe_q & ~rd_st) | (rx_vld & ~rx_take);
      toe_q  <= (toe_q & ~rd_st) | (wr_tx & ~tx_rdy);
      cts_d  <= cts_s;
      chg_q  <= (chg_q & ~rd_st) | (cts_s ^ cts_d);
    end
  end

  logic [STAT_W-1:0] stat;
  always_comb begin
    stat          = '0;
    stat[ST_PE]   = 1'b0;
    stat[ST_FE]   = fe_q;
    stat[ST_BRK]  = brk_q;
    stat[ST_ROE]  = roe_q;
    stat[ST_TOE]  = toe_q;
    stat[ST_TMT]  = tx_rdy;
    stat[ST_TRDY] = tx_rdy;
    stat[ST_RRDY] = rrdy_q;
    stat[ST_ERR]  = fe_q | brk_q | roe_q | toe_q;
    stat[ST_CHG]  = chg_q;
    stat[ST_CTS]  = cts_s;
    stat[ST_EOP]  = 1'b0;
  end

  assign irq     = |(stat & ctrl_q & IRQ_MASK);
  assign rts_out = ctrl_q[CT_RTS];

  logic [REG_W-1:0] rd_mux;
  always_comb begin
    unique case (reg_addr)
      OFF_RX:   rd_mux = REG_W'(rxd_q);
      OFF_TX:   rd_mux = REG_W'(txd_q);
      OFF_STAT: rd_mux = REG_W'(stat);
      OFF_CTRL: rd_mux = REG_W'(ctrl_q);
      OFF_DIV:  rd_mux = REG_W'(div_q);
      OFF_EOP:  rd_mux = eop_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

endmodule

// File: rtl/ser_uart_chk.sv
module ser_uart_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic        reg_rd,
  input logic [2:0]  reg_addr,
  input logic        wdata_rts,
  input logic        txd,
  input logic        irq,
  input logic        rts_out,
  input logic        tx_rdy,
  input logic        rx_vld,
  input logic        rrdy_q,
  input logic [7:0]  rxd_q,
  input logic        toe_q,
  input logic        fe_q,
  input logic [10:0] en
);

  // offsets: 0 receive data, 1 transmit data, 2 status, 3 control
  assert_rx_write_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd0 && !rx_vld) |=> $stable(rxd_q));

  assert_tx_start_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd1 && tx_rdy) |=> !txd);

  assert_tx_overrun_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd1 && !tx_rdy) |=> toe_q);

  assert_rx_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 3'd0 && !rx_vld) |=> !rrdy_q);

  assert_overrun_keeps_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_vld && rrdy_q && !(reg_rd && reg_addr == 3'd0)) |=> $stable(rxd_q));

  assert_stat_read_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 3'd2 && !rx_vld) |=> !fe_q);

  assert_no_enable_no_irq_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> !irq);

  assert_rts_follows_write_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd3) |=> (rts_out == $past(wdata_rts)));

endmodule

bind ser_uart ser_uart_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_rd    (reg_rd),
  .reg_addr  (reg_addr),
  .wdata_rts (reg_wdata[11]),
  .txd       (txd),
  .irq       (irq),
  .rts_out   (rts_out),
  .tx_rdy    (tx_rdy),
  .rx_vld    (rx_vld),
  .rrdy_q    (rrdy_q),
  .rxd_q     (rxd_q),
  .toe_q     (toe_q),
  .fe_q      (fe_q),
  .en        (ctrl_q[10:0])
);

// File: tb/tb_ser_uart.sv
`timescale 1ns/1ps
module tb_ser_uart;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic        reg_rd = 1'b0;
  logic [15:0] reg_rdata;
  logic        rxd = 1'b1;
  logic        txd;
  logic        cts_in = 1'b0;
  logic        rts_out;
  logic        irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  ser_uart #(.DIV_W(8), .DIV_INIT(5), .DATA_BITS(8)) dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .rxd(rxd), .txd(txd), .cts_in(cts_in), .rts_out(rts_out), .irq(irq)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;
  int cur_div = 5;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [7:0]  m_rxd, m_txd, m_div;
  logic [12:0] m_ctrl;
  logic [15:0] m_eop;
  bit m_fe, m_brk, m_roe, m_toe, m_rrdy, m_chg;
  bit c1, c2, c3;
  bit m_busy;
  int m_cnt, m_bit;
  logic [9:0] m_frame;
  logic [15:0] exp_rd;
  bit exp_chk;
  bit p_valid = 0, p_fe = 0, uncertain = 0;
  logic [7:0] p_byte = '0;
  bit was_rrdy, was_busy, rd_st, rd_rx;

  function automatic logic [15:0] m_stat();
    logic [15:0] s = '0;
    s[1]  = m_fe;  s[2] = m_brk; s[3] = m_roe; s[4] = m_toe;
    s[5]  = !m_busy; s[6] = !m_busy; s[7] = m_rrdy;
    s[8]  = m_fe | m_brk | m_roe | m_toe;
    s[10] = m_chg; s[11] = c2;
    return s;
  endfunction

  function automatic logic m_irq();
    logic [15:0] s = m_stat();
    for (int i = 0; i < 11; i++)
      if (i != 9 && s[i] && m_ctrl[i]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic m_txline();
    return m_busy ? m_frame[m_bit] : 1'b1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rxd = '0; m_txd = '0; m_div = 8'd5; m_ctrl = '0; m_eop = '0;
      m_fe = 0; m_brk = 0; m_roe = 0; m_toe = 0; m_rrdy = 0; m_chg = 0;
      c1 = 0; c2 = 0; c3 = 0; m_busy = 0; m_cnt = 0; m_bit = 0;
      m_frame = '1; exp_chk = 0; exp_rd = '0;
    end else begin
      exp_chk = reg_rd;
      if (reg_rd) begin
        case (reg_addr)
          3'd0: exp_rd = {8'h00, m_rxd};
          3'd1: exp_rd = {8'h00, m_txd};
          3'd2: exp_rd = m_stat();
          3'd3: exp_rd = {3'b000, m_ctrl};
          3'd4: exp_rd = {8'h00, m_div};
          3'd5: exp_rd = m_eop;
          default: exp_rd = '0;
        endcase
      end
      rd_st = reg_rd && reg_addr == 3'd2;
      rd_rx = reg_rd && reg_addr == 3'd0;
      was_rrdy = m_rrdy;
      was_busy = m_busy;
      if (rd_st) begin m_fe = 0; m_brk = 0; m_roe = 0; m_toe = 0; m_chg = 0; end
      if (rd_rx) m_rrdy = 0;
      if (p_valid) begin
        if (!was_rrdy || rd_rx) begin m_rxd = p_byte; m_rrdy = 1; end
        else m_roe = 1;
        if (p_fe) begin m_fe = 1; if (p_byte == 8'h00) m_brk = 1; end
        p_valid = 0;
        uncertain = 0;
      end
      if (c2 != c3) m_chg = 1;
      c3 = c2; c2 = c1; c1 = cts_in;
      if (was_busy) begin
        if (m_cnt != 0) m_cnt--;
        else if (m_bit == 9) m_busy = 0;
        else begin m_bit++; m_cnt = m_div; end
      end
      if (reg_wr) begin
        case (reg_addr)
          3'd1: begin
            m_txd = reg_wdata[7:0];
            if (was_busy) m_toe = 1;
            else begin
              m_busy = 1; m_bit = 0; m_cnt = m_div;
              m_frame = {1'b1, reg_wdata[7:0], 1'b0};
            end
          end
          3'd3: m_ctrl = reg_wdata[12:0];
          3'd4: m_div  = reg_wdata[7:0];
          3'd5: m_eop  = reg_wdata;
          default: ;
        endcase
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R4 txd line vs model", txd, m_txline());
      if (!uncertain) chk("R12 irq vs model", irq, m_irq());
      chk("R13 rts vs model", rts_out, m_ctrl[11]);
      if (exp_chk) chk("R2 read data vs model", reg_rdata, exp_rd);
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    chk(tag, reg_rdata, exp);
  endtask

  // write a byte and decode the frame on txd; optionally write again at bit inj
  task automatic tx_frame(input logic [7:0] b, input int inj, input string tag);
    logic [9:0] got;
    wr(3'd1, {8'h00, b});
    for (int i = 0; i < 10; i++) begin
      got[i] = txd;
      if (i == inj) begin
        reg_addr = 3'd1; reg_wdata = 16'h0055; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        repeat (cur_div) @(negedge clk);
      end else begin
        repeat (cur_div + 1) @(negedge clk);
      end
    end
    chk(tag, got, {1'b1, b, 1'b0});
  endtask

  task automatic rx_frame(input logic [7:0] b, input logic stop);
    uncertain = 1;
    @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      rxd = (i == 0) ? 1'b0 : (i == 9) ? stop : b[i-1];
      repeat (cur_div + 1) @(negedge clk);
    end
    rxd = 1'b1;
    repeat (8) @(negedge clk);
    p_byte = b; p_fe = !stop; p_valid = 1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 txd idle high", txd, 1'b1);
    chk("R1 irq low", irq, 1'b0);
    rd_chk(3'd2, 16'h0060, "R1 status after reset");
    rd_chk(3'd3, 16'h0000, "R1 control after reset");
    rd_chk(3'd4, 16'h0005, "R1 divisor after reset");

    // R2 map and widths, R12/R13 through control
    wr(3'd3, 16'h1ABC);
    chk("R13 rts high from control bit 11", rts_out, 1'b1);
    chk("R12 irq from enabled transmitter-empty", irq, 1'b1);
    rd_chk(3'd3, 16'h1ABC, "R2 control readback");
    wr(3'd3, 16'hFFFF);
    rd_chk(3'd3, 16'h1FFF, "R2 control keeps 13 bits");
    wr(3'd4, 16'h1234);
    rd_chk(3'd4, 16'h0034, "R2 divisor keeps DIV_W bits");
    wr(3'd5, 16'hBEEF);
    rd_chk(3'd5, 16'hBEEF, "R2 end-of-packet readback");
    rd_chk(3'd6, 16'h0000, "R2 unmapped offset reads zero");
    wr(3'd3, 16'h0000);
    chk("R13 rts low", rts_out, 1'b0);

    // R3 ignored writes
    wr(3'd0, 16'h00FF);
    wr(3'd2, 16'hFFFF);
    rd_chk(3'd2, 16'h0060, "R3 status unchanged by write");
    rd_chk(3'd0, 16'h0000, "R3 receive data unchanged by write");

    // R12/R13 clear-to-send path
    cts_in = 1'b1;
    repeat (5) @(negedge clk);
    wr(3'd3, 16'h0800);
    chk("R12 control bit 11 raises no irq", irq, 1'b0);
    wr(3'd3, 16'h1200);
    chk("R12 control bits 9 and 12 raise no irq", irq, 1'b0);
    wr(3'd3, 16'h0400);
    chk("R13 change flag raises irq", irq, 1'b1);
    rd_chk(3'd2, 16'h0C60, "R13 status shows cts and change");
    chk("R11 irq drops after status read", irq, 1'b0);
    rd_chk(3'd2, 16'h0860, "R11 change cleared by read");
    cts_in = 1'b0;
    repeat (5) @(negedge clk);
    rd_chk(3'd2, 16'h0460, "R13 change on falling cts");
    wr(3'd3, 16'h0000);

    // transmit
    cur_div = 2;
    wr(3'd4, 16'd2);
    tx_frame(8'hA5, -1, "R4 frame A5 at divisor 2");
    tx_frame(8'h3C, 3, "R6 frame unchanged by busy write");
    repeat (4) @(negedge clk);
    rd_chk(3'd2, 16'h0170, "R6 transmit overrun flagged");
    rd_chk(3'd2, 16'h0060, "R11 overrun cleared by read");
    rd_chk(3'd1, 16'h0055, "R2 transmit data holds last write");
    wr(3'd1, 16'h0000);
    rd_chk(3'd2, 16'h0000, "R5 ready and empty low while busy");
    repeat (40) @(negedge clk);
    rd_chk(3'd2, 16'h0060, "R5 ready and empty back after stop");
    cur_div = 0;
    wr(3'd4, 16'd0);
    tx_frame(8'h81, -1, "R4 frame 81 at divisor 0");
    repeat (3) @(negedge clk);

    // receive
    cur_div = 5;
    wr(3'd4, 16'd5);
    rx_frame(8'h5A, 1'b1);
    rd_chk(3'd2, 16'h00E0, "R7 receive ready set");
    rd_chk(3'd0, 16'h005A, "R7 received byte");
    rd_chk(3'd2, 16'h0060, "R8 receive ready cleared by data read");
    rx_frame(8'h11, 1'b1);
    rx_frame(8'h22, 1'b1);
    rd_chk(3'd2, 16'h01E8, "R9 receive overrun flagged");
    rd_chk(3'd0, 16'h0011, "R9 older byte kept");
    rd_chk(3'd2, 16'h0060, "R11 flags cleared");
    rx_frame(8'h33, 1'b0);
    rd_chk(3'd2, 16'h01E2, "R10 framing error");
    rd_chk(3'd0, 16'h0033, "R10 byte with bad stop delivered");
    rx_frame(8'h00, 1'b0);
    rd_chk(3'd2, 16'h01E6, "R10 break with framing error");
    rd_chk(3'd0, 16'h0000, "R10 break byte");

    // interrupt per cause
    wr(3'd3, 16'h0080);
    rx_frame(8'h7E, 1'b1);
    chk("R12 irq from receive ready", irq, 1'b1);
    rd_chk(3'd0, 16'h007E, "R8 read of 7E");
    chk("R8 irq drops after data read", irq, 1'b0);
    wr(3'd3, 16'h0100);
    rx_frame(8'h44, 1'b0);
    chk("R12 irq from any-error", irq, 1'b1);
    rd_chk(3'd2, 16'h01E2, "R11 error status before clear");
    chk("R11 irq drops once errors clear", irq, 1'b0);
    rd_chk(3'd0, 16'h0044, "R7 byte 44");
    wr(3'd3, 16'h0000);
    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule